// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program counter of a processor whose instructions are all 16 bits wide, and chooses the next fetch address in every cycle. In each cycle that is neither stalled nor flushed, the instruction at `fetch_addr_o` is issued. While it executes, the PC equals that instruction's own address. The decode stage supplies a pre-decoded branch descriptor for that instruction, and the compare logic supplies the T flag.

Unconditional jumps and exception returns are delayed. The next sequential instruction issues as a delay slot, and the destination follows it. Conditional branches test the T flag against a sense bit. Their plain form redirects at once when taken. Their delayed form always opens a delay slot, whether or not the branch is taken. A branch that sits in a delay slot is suppressed and raises a one-cycle slot-illegal request.

Top module: `pc_seq`

## Requirements
- R1: While rst_ni is low, fetch_addr_o equals RESET_VEC (default 0xA000_0000), and in_slot_o and slot_illegal_o are 0.
- R2: An issued instruction with br_kind_i = 0 (no branch), outside a delay slot, advances fetch_addr_o by 2 in the next cycle.
- R3: A conditional branch (br_kind_i = 1) with br_delayed_i = 0 is taken when t_flag_i equals br_sense_i. When taken, fetch_addr_o becomes the target in the next cycle and in_slot_o stays 0.
- R4: A non-delayed conditional branch that is not taken advances fetch_addr_o by 2 and opens no delay slot.
- R5: An unconditional branch (br_kind_i = 2) or an exception return (br_kind_i = 3) advances fetch_addr_o by 2 and sets in_slot_o. Once that slot instruction issues, fetch_addr_o becomes the target and in_slot_o clears.
- R6: A conditional branch with br_delayed_i = 1 always sets in_slot_o in the next cycle. After the slot instruction issues, fetch_addr_o becomes the target if the branch was taken, and the slot address plus 2 otherwise.
- R7: Branch targets are made even by clearing bit 0, so fetch_addr_o bit 0 is always 0.
- R8: A branch descriptor (br_kind_i not 0) on an instruction issued while in_slot_o is 1 raises slot_illegal_o for exactly one cycle. That branch has no effect, and the next address follows the slot rule of R5/R6.
- R9: With stall_i = 1 and flush_i = 0, fetch_addr_o, in_slot_o and the pending target are unchanged, and slot_illegal_o is 0 in the next cycle.
- R10: flush_i = 1 takes priority over stall_i and any descriptor. It clears in_slot_o and the pending target, and it leaves fetch_addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze all sequencing state |
| flush_i | input | 1 | Drop the pending target and the delay-slot state |
| br_kind_i | input | 2 | 0 none, 1 conditional, 2 unconditional, 3 exception return |
| br_sense_i | input | 1 | Conditional branch is taken when T equals this bit |
| br_delayed_i | input | 1 | Conditional branch uses the delayed form |
| br_target_i | input | ADDR_W | Branch destination address |
| t_flag_i | input | 1 | T flag from the compare logic |
| fetch_addr_o | output | ADDR_W | Current PC and fetch address |
| in_slot_o | output | 1 | Instruction at fetch_addr_o is a delay-slot instruction |
| slot_illegal_o | output | 1 | One-cycle slot-illegal exception request |

## Verification
Every result is due one clock edge after the stimulus that causes it. This applies to the new fetch address, the delay-slot flag and the slot-illegal pulse, since each comes straight from a single register. A delayed branch's destination shows up one issue cycle later, after the slot instruction. The bench applies its inputs just after a rising edge, updates a reference model once per edge, and compares all three outputs 2 ns after the following edge. Stalls inserted between a branch and its slot therefore check that the pending target waits without any timing slip.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    BR_NONE   = 2'd0,
    BR_COND   = 2'd1,
    BR_UNCOND = 2'd2,
    BR_RTE    = 2'd3
  } br_kind_e;

  localparam int unsigned INSTR_BYTES = 2;
endpackage

// File: rtl/pc_seq_branch_eval.sv
module pc_seq_branch_eval
  import pc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [1:0]        kind_i,
  input  logic              sense_i,
  input  logic              delayed_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              t_flag_i,
  input  logic              in_slot_i,
  output logic              redirect_now_o,
  output logic              delay_open_o,
  output logic              delay_take_o,
  output logic              illegal_o,
  output logic [ADDR_W-1:0] tgt_even_o
);
  br_kind_e kind;
  logic is_br, active, is_delayed, taken;

  assign kind = br_kind_e'(kind_i);

  always_comb begin
    is_br      = (kind != BR_NONE);
    active     = is_br & ~in_slot_i;
    is_delayed = (kind == BR_UNCOND) | (kind == BR_RTE) |
                 ((kind == BR_COND) & delayed_i);
    taken      = (kind == BR_COND) ? (t_flag_i == sense_i) : 1'b1;
  end

  assign illegal_o      = is_br & in_slot_i;
  assign redirect_now_o = active & ~is_delayed & taken;
  assign delay_open_o   = active & is_delayed;
  assign delay_take_o   = active & is_delayed & taken;
  // instructions are halfword aligned
  assign tgt_even_o     = {target_i[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/pc_seq_slot_ctl.sv
module pc_seq_slot_ctl #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              flush_i,
  input  logic              delay_open_i,
  input  logic              delay_take_i,
  input  logic              illegal_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic              in_slot_o,
  output logic              pend_v_o,
  output logic [ADDR_W-1:0] pend_tgt_o,
  output logic              illegal_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_o  <= 1'b0;
      pend_v_o   <= 1'b0;
      pend_tgt_o <= '0;
      illegal_o  <= 1'b0;
    end else if (flush_i) begin
      in_slot_o <= 1'b0;
      pend_v_o  <= 1'b0;
      illegal_o <= 1'b0;
    end else if (adv_i) begin
      in_slot_o <= delay_open_i;
      pend_v_o  <= delay_take_i;
      illegal_o <= illegal_i;
      if (delay_take_i) pend_tgt_o <= tgt_i;
    end else begin
      illegal_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hA000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              flush_i,
  input  logic [1:0]        br_kind_i,
  input  logic              br_sense_i,
  input  logic              br_delayed_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              t_flag_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              in_slot_o,
  output logic              slot_illegal_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic              adv;
  logic              redirect_now, delay_open, delay_take, illegal;
  logic [ADDR_W-1:0] tgt_even, pend_tgt, pc_q, pc_d;
  logic              in_slot, pend_v;

  assign adv = ~stall_i & ~flush_i;

  pc_seq_branch_eval #(.ADDR_W(ADDR_W)) u_eval (
    .kind_i         (br_kind_i),
    .sense_i        (br_sense_i),
    .delayed_i      (br_delayed_i),
    .target_i       (br_target_i),
    .t_flag_i       (t_flag_i),
    .in_slot_i      (in_slot),
    .redirect_now_o (redirect_now),
    .delay_open_o   (delay_open),
    .delay_take_o   (delay_take),
    .illegal_o      (illegal),
    .tgt_even_o     (tgt_even)
  );

  pc_seq_slot_ctl #(.ADDR_W(ADDR_W)) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .flush_i      (flush_i),
    .delay_open_i (delay_open),
    .delay_take_i (delay_take),
    .illegal_i    (illegal),
    .tgt_i        (tgt_even),
    .in_slot_o    (in_slot),
    .pend_v_o     (pend_v),
    .pend_tgt_o   (pend_tgt),
    .illegal_o    (slot_illegal_o)
  );

  always_comb begin
    pc_d = pc_q;
    if (adv) begin
      if (in_slot && pend_v) pc_d = pend_tgt;
      else if (redirect_now) pc_d = tgt_even;
      else                   pc_d = pc_q + STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_VEC;
    else         pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign in_slot_o    = in_slot;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              flush_i,
  input logic [1:0]        br_kind_i,
  input logic              br_sense_i,
  input logic              br_delayed_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic              t_flag_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              in_slot_o,
  input logic              slot_illegal_o
);
  logic issue;
  assign issue = !stall_i && !flush_i;

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && !in_slot_o && br_kind_i == 2'd0 |=> fetch_addr_o == $past(fetch_addr_o) + 2);

  a_r3_cond_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && !in_slot_o && br_kind_i == 2'd1 && !br_delayed_i && (t_flag_i == br_sense_i)
    |=> fetch_addr_o == {$past(br_target_i[ADDR_W-1:1]), 1'b0} && !in_slot_o);

  a_r6_delayed_opens_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && !in_slot_o && br_kind_i == 2'd1 && br_delayed_i |=> in_slot_o);

  a_r7_even_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o[0] == 1'b0);

  a_r8_illegal_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && in_slot_o && br_kind_i != 2'd0 |=> slot_illegal_o && !in_slot_o);

  a_r8_illegal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_illegal_o |=> !slot_illegal_o);

  a_r9_stall_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i && !flush_i |=> $stable(fetch_addr_o) && $stable(in_slot_o) && !slot_illegal_o);

  a_r10_flush_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !in_slot_o && $stable(fetch_addr_o) && !slot_illegal_o);
endmodule

bind pc_seq pc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stall_i        (stall_i),
  .flush_i        (flush_i),
  .br_kind_i      (br_kind_i),
  .br_sense_i     (br_sense_i),
  .br_delayed_i   (br_delayed_i),
  .br_target_i    (br_target_i),
  .t_flag_i       (t_flag_i),
  .fetch_addr_o   (fetch_addr_o),
  .in_slot_o      (in_slot_o),
  .slot_illegal_o (slot_illegal_o)
);

// File: tb/tb_pc_seq.sv
`timescale 1ns/1ps
module tb_pc_seq;
  localparam int unsigned AW = 32;
  localparam logic [AW-1:0] RV = 32'hA000_0000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stall, flush, sense, dly, tflag;
  logic [1:0] kind;
  logic [AW-1:0] tgt;
  logic [AW-1:0] fetch_addr;
  logic in_slot, illegal;

  int errors = 0, checks = 0;
  logic [AW-1:0] m_pc, m_pt;
  logic m_slot, m_pv, m_ill;

  always #4 clk = ~clk;

  pc_seq #(.ADDR_W(AW), .RESET_VEC(RV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall), .flush_i(flush),
    .br_kind_i(kind), .br_sense_i(sense), .br_delayed_i(dly),
    .br_target_i(tgt), .t_flag_i(tflag),
    .fetch_addr_o(fetch_addr), .in_slot_o(in_slot), .slot_illegal_o(illegal)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic s, logic f, logic [1:0] k, logic d, logic tk,
                                   logic [AW-1:0] t);
    if (f) return "R10";
    if (s) return "R9";
    if (m_slot && k != 2'd0) return "R8";
    if (m_slot) return (m_pv ? "R5" : "R6");
    if (k == 2'd0) return "R2";
    if (k == 2'd1 && !d) return tk ? (t[0] ? "R7" : "R3") : "R4";
    if (k == 2'd1) return "R6";
    return "R5";
  endfunction

  // one issue cycle: drive, advance model, check after the edge
  task automatic step(logic s, logic f, logic [1:0] k, logic sn, logic d,
                      logic [AW-1:0] t, logic tf);
    logic tk, is_dly;
    logic [AW-1:0] te;
    string req;
    stall = s; flush = f; kind = k; sense = sn; dly = d; tgt = t; tflag = tf;
    tk = (k == 2'd1) ? (tf == sn) : 1'b1;
    is_dly = (k == 2'd2) || (k == 2'd3) || (k == 2'd1 && d);
    te = {t[AW-1:1], 1'b0};
    req = tag_of(s, f, k, d, tk, t);
    if (f) begin
      m_slot = 0; m_pv = 0; m_ill = 0;
    end else if (s) begin
      m_ill = 0;
    end else if (m_slot) begin
      m_ill = (k != 2'd0);
      m_pc = m_pv ? m_pt : m_pc + 2;
      m_slot = 0; m_pv = 0;
    end else begin
      m_ill = 0;
      if (k == 2'd0) m_pc = m_pc + 2;
      else if (!is_dly) m_pc = tk ? te : m_pc + 2;
      else begin
        m_slot = 1; m_pv = tk;
        if (tk) m_pt = te;
        m_pc = m_pc + 2;
      end
    end
    @(posedge clk); #2;
    check({req, " pc"}, fetch_addr, m_pc);
    check({req, " slot"}, AW'(in_slot), AW'(m_slot));
    check({req, " illegal"}, AW'(illegal), AW'(m_ill));
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    stall = 0; flush = 0; kind = 0; sense = 0; dly = 0; tgt = '0; tflag = 0;
    m_pc = RV; m_pt = '0; m_slot = 0; m_pv = 0; m_ill = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 pc", fetch_addr, RV);
    check("R1 slot", AW'(in_slot), '0);
    check("R1 illegal", AW'(illegal), '0);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #2;  // first edge after release: no-branch issue
    m_pc = m_pc + 2;
    check("R2 first", fetch_addr, m_pc);

    step(0,0,2'd0,0,0,'0,0);                  // R2
    step(0,0,2'd1,1,0,32'h0000_1000,1);       // R3 taken
    step(0,0,2'd1,1,0,32'h0000_2000,0);       // R4 not taken
    step(0,0,2'd2,0,0,32'h0000_3000,0);       // R5 uncond
    step(0,0,2'd0,0,0,'0,0);                  // slot -> target
    step(0,0,2'd3,0,0,32'h0000_4000,0);       // R5 return
    step(1,0,2'd0,0,0,'0,0);                  // R9 stall in slot
    step(1,0,2'd2,0,0,32'h0000_9990,0);       // R9 stall ignores descriptor
    step(0,0,2'd0,0,0,'0,0);                  // slot issue -> pending
    step(0,0,2'd1,0,1,32'h0000_5000,0);       // R6 delayed taken
    step(0,0,2'd0,0,0,'0,0);
    step(0,0,2'd1,0,1,32'h0000_6000,1);       // R6 delayed not taken
    step(0,0,2'd0,0,0,'0,0);
    step(0,0,2'd1,0,0,32'h0000_7001,0);       // R7 odd target
    step(0,0,2'd2,0,0,32'h0000_8000,0);
    step(0,0,2'd2,0,0,32'h0000_A000,0);       // R8 branch in slot
    step(0,0,2'd0,0,0,'0,0);
    step(0,0,2'd2,0,0,32'h0000_B000,0);
    step(1,1,2'd0,0,0,'0,0);                  // R10 flush beats stall
    step(0,0,2'd0,0,0,'0,0);

    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [1:0] k = (r < 50) ? 2'd0 : (r < 75) ? 2'd1 : (r < 90) ? 2'd2 : 2'd3;
      step($urandom_range(0, 9) == 0, $urandom_range(0, 29) == 0, k,
           1'($urandom), 1'($urandom), $urandom, 1'($urandom));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule